// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside the control port of a parallel NOR-style flash array and watches every write cycle presented on it. Writes arrive as a single-cycle strobe carrying a 22-bit word address and a 16-bit data word. The block recognises the multi-write unlock and command patterns used to start programming, to erase the whole array or one sector, to suspend or resume an erase, and to enter or leave the identification, query and fast-program modes. Each recognised command comes out as a one-cycle pulse together with the captured address, data and bank of the write that completed it. The embedded algorithms that act on these pulses consume them downstream.

Unlock patterns match only the low eleven address bits and the low data byte. A `busy` input from the algorithm engine blocks every write except reset and suspend. An `erasing` input states that a sector erase is running, which is the only time a suspend is accepted. The block reports its current base mode so that a read-data multiplexer can choose between array data, identification codes, query data or suspend-read behaviour.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, mode becomes 0 (array read), every command pulse is 0, tgt_addr, tgt_data and tgt_bank become 0, and any partial sequence is discarded.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h and then any data D at any address A raise cmd_program for exactly one cycle, in the cycle after the fourth write. In that same cycle tgt_addr=A, tgt_data=D and tgt_bank=A[21:19].
- R3: Unlock and command writes compare only address bits [10:0] and data bits [7:0]. Higher bits take any value.
- R4: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise cmd_chip_erase for one cycle after the sixth write.
- R5: The same five-write prefix followed by 30h at any address A raises cmd_sector_erase for one cycle, with tgt_addr=A.
- R6: A write that does not fit the expected next step ends the partial sequence with no pulse. The base mode is kept, including unlock-bypass mode (3).
- R7: AAh@555h, 55h@2AAh, 90h@555h (any bank bits) sets mode 1 (autoselect) and captures that write's address, data and bank.
- R8: A single write of 98h to address 055h sets mode 2 (query) from array, autoselect or suspend mode.
- R9: AAh@555h, 55h@2AAh, 20h@555h sets mode 3 (unlock bypass). In mode 3, A0h then D@A gives cmd_program, 80h then 10h gives cmd_chip_erase, and 90h then 00h returns mode to 0. Every other write is ignored or aborts.
- R10: B0h at address A raises cmd_suspend and sets mode 4 only while erasing=1, and captures A. 30h raises cmd_resume and sets mode 0 only when mode is 4.
- R11: F0h at any address, outside mode 3 and outside the data write of a program, raises cmd_reset. Mode goes to 4 if an erase is suspended and not yet resumed, otherwise to 0. In mode 3, F0h has no effect.
- R12: While busy=1, every write other than F0h and B0h leaves mode, sequence progress and pulses unchanged.
- R13: At most one command pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 22 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| busy | input | 1 | Program or erase algorithm running |
| erasing | input | 1 | Sector erase in progress |
| cmd_program | output | 1 | Program command pulse |
| cmd_chip_erase | output | 1 | Chip erase command pulse |
| cmd_sector_erase | output | 1 | Sector erase command pulse |
| cmd_suspend | output | 1 | Erase suspend pulse |
| cmd_resume | output | 1 | Erase resume pulse |
| cmd_reset | output | 1 | Reset command pulse |
| tgt_addr | output | 22 | Address of the write that completed the last command |
| tgt_data | output | 16 | Data of that write |
| tgt_bank | output | 3 | Bank field of tgt_addr |
| mode | output | 3 | 0 array, 1 autoselect, 2 query, 3 bypass, 4 suspend |

## Verification
A corrupted step register stays hidden until the write that would finish a sequence. It then shows up as a missing or wrong pulse one cycle after that write, or as a pulse after a sequence that was broken. A wrong base mode shows on the mode output in the cycle after the write that caused it. A lost suspend flag shows only on the next reset command, when mode comes back 0 instead of 4. For that reason the vectors walk each sequence to its last write and issue a reset inside suspend.

// File: rtl/flash_cmd_pkg.sv
// Shared types for the flash command decoder: base modes, sequence
// steps, classified write codes and the command pulse bundle.
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        MODE_ARRAY   = 3'd0,
        MODE_AUTOSEL = 3'd1,
        MODE_QUERY   = 3'd2,
        MODE_BYPASS  = 3'd3,
        MODE_SUSPEND = 3'd4
    } mode_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_U1, ST_U2, ST_PGM, ST_E1, ST_E2, ST_E3,
        ST_BP_PGM, ST_BP_ERA, ST_BP_EXIT
    } step_e;

    typedef enum logic [3:0] {
        K_AA, K_55, K_A0, K_80, K_90, K_20, K_10, K_30,
        K_F0, K_B0, K_98, K_00, K_OTHER
    } code_e;

    typedef struct packed {
        logic prog;
        logic chip;
        logic sect;
        logic susp;
        logic resume;
        logic rst;
    } pulse_t;

endpackage

// File: rtl/flash_cmd_classify.sv
// Combinational classifier. It sorts the low data byte into a command
// code and flags the three unlock addresses.
// Assumes: the caller passes only the low address bits that take part
// in matching and only the low data byte.
module flash_cmd_classify
    import flash_cmd_pkg::*;
#(
    parameter int MATCH_W = 11
) (
    input  logic [MATCH_W-1:0] addr_lo,
    input  logic [7:0]         data_lo,
    output code_e              code,
    output logic               at_555,
    output logic               at_2aa,
    output logic               at_055
);
    localparam logic [MATCH_W-1:0] ADR_555 = MATCH_W'(12'h555);
    localparam logic [MATCH_W-1:0] ADR_2AA = MATCH_W'(12'h2AA);
    localparam logic [MATCH_W-1:0] ADR_055 = MATCH_W'(12'h055);

    // Purpose: flag the unlock and query addresses.
    always_comb begin
        at_555 = (addr_lo == ADR_555);
        at_2aa = (addr_lo == ADR_2AA);
        at_055 = (addr_lo == ADR_055);
    end

    // Purpose: map the low data byte onto a command code.
    always_comb begin
        unique case (data_lo)
            8'hAA:   code = K_AA;
            8'h55:   code = K_55;
            8'hA0:   code = K_A0;
            8'h80:   code = K_80;
            8'h90:   code = K_90;
            8'h20:   code = K_20;
            8'h10:   code = K_10;
            8'h30:   code = K_30;
            8'hF0:   code = K_F0;
            8'hB0:   code = K_B0;
            8'h98:   code = K_98;
            8'h00:   code = K_00;
            default: code = K_OTHER;
        endcase
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
// Sequence state machine. It tracks the step within a multi-write
// sequence, the base mode and the suspended-erase flag, and it issues
// the registered command pulses together with a capture strobe.
// Assumes: the write inputs are classified in the same cycle; busy and
// erasing are synchronous to clk.
module flash_cmd_fsm
    import flash_cmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  code_e  code,
    input  logic   at_555,
    input  logic   at_2aa,
    input  logic   at_055,
    input  logic   busy,
    input  logic   erasing,
    output pulse_t pulse,
    output logic   cap,
    output mode_e  mode
);
    step_e  step, step_n;
    mode_e  mode_n;
    logic   susp, susp_n;
    pulse_t pulse_n;
    logic   is_rst, is_susp;

    // Purpose: find the commands that bypass the busy gate.
    always_comb begin
        is_rst  = wr_en && code == K_F0 && mode != MODE_BYPASS && step != ST_PGM;
        is_susp = wr_en && code == K_B0 && erasing && mode != MODE_BYPASS && step != ST_PGM;
    end

    // Purpose: next step, mode, suspend flag, pulses and capture strobe.
    always_comb begin
        step_n  = step;
        mode_n  = mode;
        susp_n  = susp;
        pulse_n = '0;
        cap     = 1'b0;
        if (is_rst) begin
            pulse_n.rst = 1'b1;
            step_n      = ST_IDLE;
            mode_n      = susp ? MODE_SUSPEND : MODE_ARRAY;
        end else if (is_susp) begin
            pulse_n.susp = 1'b1;
            cap          = 1'b1;
            step_n       = ST_IDLE;
            mode_n       = MODE_SUSPEND;
            susp_n       = 1'b1;
        end else if (wr_en && !busy) begin
            step_n = ST_IDLE;
            unique case (step)
                ST_IDLE: begin
                    if (mode == MODE_BYPASS) begin
                        if (code == K_A0)      step_n = ST_BP_PGM;
                        else if (code == K_80) step_n = ST_BP_ERA;
                        else if (code == K_90) step_n = ST_BP_EXIT;
                    end else if (mode == MODE_SUSPEND && code == K_30) begin
                        pulse_n.resume = 1'b1;
                        cap            = 1'b1;
                        mode_n         = MODE_ARRAY;
                        susp_n         = 1'b0;
                    end else if (code == K_98 && at_055) begin
                        mode_n = MODE_QUERY;
                    end else if (code == K_AA && at_555) begin
                        step_n = ST_U1;
                    end
                end
                ST_U1: if (code == K_55 && at_2aa) step_n = ST_U2;
                ST_U2: if (at_555) begin
                    if (code == K_A0)      step_n = ST_PGM;
                    else if (code == K_80) step_n = ST_E1;
                    else if (code == K_90) begin
                        mode_n = MODE_AUTOSEL;
                        cap    = 1'b1;
                    end else if (code == K_20) mode_n = MODE_BYPASS;
                end
                ST_PGM, ST_BP_PGM: begin
                    pulse_n.prog = 1'b1;
                    cap          = 1'b1;
                end
                ST_E1: if (code == K_AA && at_555) step_n = ST_E2;
                ST_E2: if (code == K_55 && at_2aa) step_n = ST_E3;
                ST_E3: begin
                    if (code == K_10 && at_555) begin
                        pulse_n.chip = 1'b1;
                        cap          = 1'b1;
                    end else if (code == K_30) begin
                        pulse_n.sect = 1'b1;
                        cap          = 1'b1;
                    end
                end
                ST_BP_ERA: if (code == K_10) begin
                    pulse_n.chip = 1'b1;
                    cap          = 1'b1;
                end
                ST_BP_EXIT: if (code == K_00) mode_n = MODE_ARRAY;
                default: step_n = ST_IDLE;
            endcase
        end
    end

    // Purpose: state and pulse registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step  <= ST_IDLE;
            mode  <= MODE_ARRAY;
            susp  <= 1'b0;
            pulse <= '0;
        end else begin
            step  <= step_n;
            mode  <= mode_n;
            susp  <= susp_n;
            pulse <= pulse_n;
        end
    end

    p_single_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse));
    p_suspend_needs_erase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse.susp |-> $past(erasing));
    p_resume_from_suspend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse.resume |-> $past(mode) == MODE_SUSPEND);
    p_busy_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy && code != K_F0 && code != K_B0)
        |=> (pulse == '0 && mode == $past(mode) && step == $past(step)));
    p_reset_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse.rst |-> (mode == MODE_ARRAY || mode == MODE_SUSPEND));
    p_bypass_no_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == MODE_BYPASS) |=> !pulse.rst);
endmodule

// File: rtl/flash_cmd_capture.sv
// Target register. It holds the address, data and bank field of the
// write that completed the most recent capturing command.
// Assumes: cap is high only in the cycle of that completing write.
module flash_cmd_capture #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic [BANK_W-1:0] tgt_bank
);
    localparam int BANK_LSB = ADDR_W - BANK_W;

    // Purpose: load the target fields on the capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_addr <= '0;
            tgt_data <= '0;
            tgt_bank <= '0;
        end else if (cap) begin
            tgt_addr <= addr;
            tgt_data <= data;
            tgt_bank <= addr[ADDR_W-1:BANK_LSB];
        end
    end

    p_hold_without_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(tgt_addr) && $stable(tgt_data));
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder. It ties the classifier, the
// sequence state machine and the target register together.
// Assumes: one write per strobe cycle; all inputs synchronous to clk.
module flash_cmd_decoder #(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 16,
    parameter int BANK_W  = 3,
    parameter int MATCH_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              erasing,
    output logic              cmd_program,
    output logic              cmd_chip_erase,
    output logic              cmd_sector_erase,
    output logic              cmd_suspend,
    output logic              cmd_resume,
    output logic              cmd_reset,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic [BANK_W-1:0] tgt_bank,
    output logic [2:0]        mode
);
    import flash_cmd_pkg::*;

    code_e  code;
    logic   at_555, at_2aa, at_055, cap;
    pulse_t pulse;
    mode_e  mode_q;

    flash_cmd_classify #(.MATCH_W(MATCH_W)) u_classify (
        .addr_lo (wr_addr[MATCH_W-1:0]),
        .data_lo (wr_data[7:0]),
        .code    (code),
        .at_555  (at_555),
        .at_2aa  (at_2aa),
        .at_055  (at_055)
    );

    flash_cmd_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .code    (code),
        .at_555  (at_555),
        .at_2aa  (at_2aa),
        .at_055  (at_055),
        .busy    (busy),
        .erasing (erasing),
        .pulse   (pulse),
        .cap     (cap),
        .mode    (mode_q)
    );

    flash_cmd_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .addr     (wr_addr),
        .data     (wr_data),
        .tgt_addr (tgt_addr),
        .tgt_data (tgt_data),
        .tgt_bank (tgt_bank)
    );

    // Purpose: fan the pulse bundle and mode out to the ports.
    always_comb begin
        cmd_program      = pulse.prog;
        cmd_chip_erase   = pulse.chip;
        cmd_sector_erase = pulse.sect;
        cmd_suspend      = pulse.susp;
        cmd_resume       = pulse.resume;
        cmd_reset        = pulse.rst;
        mode             = mode_q;
    end
endmodule

// File: tb/flash_cmd_decoder_bench.sv
// Vector-driven bench for the flash command decoder, followed by
// directed reset tests.
module flash_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [21:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy = 1'b0;
    logic        erasing = 1'b0;
    logic        cmd_program, cmd_chip_erase, cmd_sector_erase;
    logic        cmd_suspend, cmd_resume, cmd_reset;
    logic [21:0] tgt_addr;
    logic [15:0] tgt_data;
    logic [2:0]  tgt_bank;
    logic [2:0]  mode;
    int          n_run = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .erasing(erasing),
        .cmd_program(cmd_program), .cmd_chip_erase(cmd_chip_erase),
        .cmd_sector_erase(cmd_sector_erase), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data), .tgt_bank(tgt_bank),
        .mode(mode)
    );

    // Vector: addr(22) data(16) busy erasing pulses{prog,chip,sect,susp,res,rst} mode(3) capture
    localparam int NV = 53;
    localparam logic [49:0] VEC [0:NV-1] = '{
        {22'h000555,16'h00AA,1'b0,1'b0,6'b000000,3'd0,1'b0}, // R2 unlock 1
        {22'h0002AA,16'h0055,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h000555,16'h00A0,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h123456,16'hBEEF,1'b0,1'b0,6'b100000,3'd0,1'b1}, // R2 program pulse
        {22'h3FF555,16'h12AA,1'b0,1'b0,6'b000000,3'd0,1'b0}, // R3 high bits set
        {22'h02AAAA,16'hFF55,1'b0,1'b0,6'b000000,3'd0,1'b0}, // R3
        {22'h000555,16'h0080,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h000555,16'h00AA,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h0002AA,16'h0055,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h1FF555,16'hAB10,1'b0,1'b0,6'b010000,3'd0,1'b1}, // R4 chip erase
        {22'h000555,16'h00AA,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h0002AA,16'h0055,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h000555,16'h0080,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h000555,16'h00AA,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h0002AA,16'h0055,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h2A5000,16'h0030,1'b0,1'b0,6'b001000,3'd0,1'b1}, // R5 sector erase
        {22'h000555,16'h00AA,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h0002AA,16'h0056,1'b0,1'b0,6'b000000,3'd0,1'b0}, // R6 broken
        {22'h000555,16'h00A0,1'b0,1'b0,6'b000000,3'd0,1'b0}, // R6
        {22'h000100,16'h1111,1'b0,1'b0,6'b000000,3'd0,1'b0}, // R6 no program
        {22'h000555,16'h00AA,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h0002AA,16'h0055,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h180555,16'h0090,1'b0,1'b0,6'b000000,3'd1,1'b1}, // R7 autoselect
        {22'h000000,16'h00F0,1'b0,1'b0,6'b000001,3'd0,1'b0}, // R11 reset
        {22'h000055,16'h0098,1'b0,1'b0,6'b000000,3'd2,1'b0}, // R8 query
        {22'h000000,16'h00F0,1'b0,1'b0,6'b000001,3'd0,1'b0}, // R8 leave
        {22'h000555,16'h00AA,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h0002AA,16'h0055,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h000555,16'h0020,1'b0,1'b0,6'b000000,3'd3,1'b0}, // R9 bypass
        {22'h000000,16'h00A0,1'b0,1'b0,6'b000000,3'd3,1'b0},
        {22'h000ABC,16'h1234,1'b0,1'b0,6'b100000,3'd3,1'b1}, // R9 program
        {22'h000000,16'h0080,1'b0,1'b0,6'b000000,3'd3,1'b0},
        {22'h000000,16'h0010,1'b0,1'b0,6'b010000,3'd3,1'b1}, // R9 chip erase
        {22'h000000,16'h00F0,1'b0,1'b0,6'b000000,3'd3,1'b0}, // R11 no reset in bypass
        {22'h000555,16'h0080,1'b0,1'b0,6'b000000,3'd3,1'b0},
        {22'h000555,16'h0077,1'b0,1'b0,6'b000000,3'd3,1'b0}, // R6 abort stays bypass
        {22'h000000,16'h00A0,1'b0,1'b0,6'b000000,3'd3,1'b0},
        {22'h000777,16'h5A5A,1'b0,1'b0,6'b100000,3'd3,1'b1}, // R6 bypass intact
        {22'h000000,16'h0090,1'b0,1'b0,6'b000000,3'd3,1'b0},
        {22'h000000,16'h0000,1'b0,1'b0,6'b000000,3'd0,1'b0}, // R9 exit
        {22'h100000,16'h00B0,1'b0,1'b0,6'b000000,3'd0,1'b0}, // R10 no erase
        {22'h300000,16'h00B0,1'b1,1'b1,6'b000100,3'd4,1'b1}, // R10 R12 suspend
        {22'h000000,16'h00F0,1'b0,1'b0,6'b000001,3'd4,1'b0}, // R11 back to suspend
        {22'h000555,16'h00AA,1'b0,1'b0,6'b000000,3'd4,1'b0},
        {22'h0002AA,16'h0055,1'b0,1'b0,6'b000000,3'd4,1'b0},
        {22'h355555,16'h0090,1'b0,1'b0,6'b000000,3'd1,1'b1}, // R7
        {22'h000000,16'h00F0,1'b0,1'b0,6'b000001,3'd4,1'b0}, // R11
        {22'h200000,16'h0030,1'b0,1'b0,6'b000010,3'd0,1'b1}, // R10 resume
        {22'h000000,16'h0030,1'b0,1'b0,6'b000000,3'd0,1'b0}, // R10 resume ignored
        {22'h000555,16'h00AA,1'b1,1'b0,6'b000000,3'd0,1'b0}, // R12 busy
        {22'h0002AA,16'h0055,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h000555,16'h00A0,1'b0,1'b0,6'b000000,3'd0,1'b0},
        {22'h000321,16'h4321,1'b0,1'b0,6'b000000,3'd0,1'b0}  // R12 no program
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [21:0] a, input logic [15:0] d, input logic b, input logic e);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; busy = b; erasing = e;
        @(negedge clk);
        wr_en = 1'b0; busy = 1'b0; erasing = 1'b0;
    endtask

    function automatic logic [5:0] pulses();
        return {cmd_program, cmd_chip_erase, cmd_sector_erase, cmd_suspend, cmd_resume, cmd_reset};
    endfunction

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 mode", 64'(mode), 64'd0);
        check("R1 pulses", 64'(pulses()), 64'd0);
        check("R1 target", 64'({tgt_addr, tgt_data, tgt_bank}), 64'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][49:28], VEC[i][27:12], VEC[i][11], VEC[i][10]);
            check($sformatf("vector %0d pulses", i), 64'(pulses()), 64'(VEC[i][9:4]));
            check($sformatf("vector %0d mode", i), 64'(mode), 64'(VEC[i][3:1]));
            if (VEC[i][0]) begin
                // R2 target capture with bank = address bits [21:19]
                check($sformatf("R2 vector %0d tgt_addr", i), 64'(tgt_addr), 64'(VEC[i][49:28]));
                check($sformatf("R2 vector %0d tgt_data", i), 64'(tgt_data), 64'(VEC[i][27:12]));
                check($sformatf("R2 vector %0d tgt_bank", i), 64'(tgt_bank), 64'(VEC[i][49:47]));
            end
        end
        // R1: reset in mid-sequence discards the partial sequence
        do_write(22'h000555, 16'h00AA, 1'b0, 1'b0);
        do_write(22'h0002AA, 16'h0055, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 target after reset", 64'({tgt_addr, tgt_data, tgt_bank}), 64'd0);
        do_write(22'h000555, 16'h00A0, 1'b0, 1'b0);
        do_write(22'h000444, 16'h4444, 1'b0, 1'b0);
        check("R1 no program after reset", 64'(cmd_program), 64'd0);
        // R1: reset leaves bypass mode
        do_write(22'h000555, 16'h00AA, 1'b0, 1'b0);
        do_write(22'h0002AA, 16'h0055, 1'b0, 1'b0);
        do_write(22'h000555, 16'h0020, 1'b0, 1'b0);
        check("R9 bypass entry", 64'(mode), 64'd3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 mode after reset", 64'(mode), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule